// File: doc/BRIEF.md
# External Instruction Fetch Packer

This block turns one 48-bit read request into a pair of reads on a 32-bit external memory bus and joins the two pieces into a single 48-bit word. It serves instruction fetches and loads of the 48-bit exchange register. A request carries a 24-bit internal word address and a one-bit type. The packer remaps that address to the external byte-pair layout. It reads the even external location first and the odd one right after it, then presents the assembled word together with a one-cycle done pulse.

External memory stretches either read by holding its acknowledge low. Only the external bank that begins at word 0x02_0000 can supply these words. A request that falls below that bank is refused with a one-cycle error pulse, and no bus activity follows. The packer handles one request at a time: a request that arrives while a transfer is under way is dropped.

Top module: `xfetch_packer`

## Requirements
- R1: An accepted request at internal address A produces two reads, first at external address {A[23:17], A[15:0], 0} and then at {A[23:17], A[15:0], 1}; internal bit 16 is discarded (for example 0x020008 reads 0x020010 then 0x020011).
- R2: The assembled word takes bits 15:0 from bits 15:0 of the data returned by the first (even) read, and bits 47:16 from all 32 bits of the data returned by the second (odd) read.
- R3: The bank select and the read strobe are both high for every cycle of each read and both low in idle; the bank select is high only while external address bits 23:17 are nonzero; the external address is zero in idle.
- R4: While the acknowledge is low, the current read is held with the same address, select and strobe, and the data lines are not captured.
- R5: The done output is high for exactly one cycle, the cycle after the acknowledge of the second read; the assembled word is valid then and holds its value until the next word is assembled.
- R6: A request whose address bits 23:17 are all zero, of either type, gives an error pulse of one cycle in the next cycle and starts no read.
- R7: A request that arrives while a transfer is in progress, including its done cycle, is ignored and does not alter the address being read.
- R8: During the done pulse the type output echoes the request type (0 = instruction fetch, 1 = exchange-register load); it is 0 at all other times.
- R9: An active-low reset returns the block to idle at once, with select, strobe, done, error and external address all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_kind | input | 1 | 0 = instruction fetch, 1 = exchange-register load |
| req_addr | input | 24 | Internal word address |
| ext_addr | output | 24 | External memory address |
| ext_cs | output | 1 | Bank select for the instruction bank |
| ext_rd | output | 1 | Read strobe |
| ext_ack | input | 1 | Acknowledge; low inserts wait states |
| ext_rdata | input | 32 | Data returned by external memory |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_kind | output | 1 | Request type echoed with the done pulse |
| rsp_data | output | 48 | Assembled 48-bit word |
| rsp_err | output | 1 | One-cycle pulse for a refused request |

## Verification
A sequencer stuck in the wrong phase shows at the ports in the cycle it is entered. The external address's lowest bit would be wrong, or the select and strobe would be up while idle, and the bench compares the address on every cycle of every read. A capture register loaded on the wrong edge only shows when the done pulse samples the word, so each done cycle is checked against data that the bench model changes with the address. During wait cycles the data lines carry junk, so any capture without acknowledge corrupts the result. A phase that is skipped or repeated moves the done pulse one cycle off, and the bench samples it in a fixed cycle.

// File: rtl/xfp_pkg.sv
package xfp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } xfp_state_e;

  typedef enum logic {
    KIND_FETCH = 1'b0,
    KIND_XREG  = 1'b1
  } xfp_kind_e;
endpackage

// File: rtl/xfp_addr_map.sv
module xfp_addr_map #(
  parameter int ADDR_W   = 24,
  parameter int BANK_LSB = 17
) (
  input  logic [ADDR_W-1:0] held_addr,
  input  logic              phase_odd,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [ADDR_W-1:0] mapped_addr,
  output logic              probe_in_bank
);
  localparam int BANK_W = ADDR_W - BANK_LSB;
  localparam int OFFS_W = BANK_LSB - 1;

  logic [BANK_W-1:0] bank_bits;
  logic [OFFS_W-1:0] offs_bits;
  logic              unused_drop_bit;

  // bank field stays in place, offset moves up by one, bit 0 picks the half
  assign bank_bits       = held_addr[ADDR_W-1:BANK_LSB];
  assign offs_bits       = held_addr[OFFS_W-1:0];
  assign unused_drop_bit = held_addr[BANK_LSB-1];
  assign mapped_addr     = {bank_bits, offs_bits, phase_odd};

  assign probe_in_bank   = |probe_addr[ADDR_W-1:BANK_LSB];
endmodule

// File: rtl/xfp_ctrl.sv
module xfp_ctrl
  import xfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_in_bank,
  input  logic       ext_ack,
  output xfp_state_e state,
  output logic       load_req,
  output logic       cap_low,
  output logic       cap_high,
  output logic       err_pulse
);
  xfp_state_e state_q, state_d;
  logic       err_q, err_d;

  always_comb begin
    state_d  = state_q;
    load_req = 1'b0;
    cap_low  = 1'b0;
    cap_high = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_in_bank) begin
            load_req = 1'b1;
            state_d  = ST_LOW;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (ext_ack) begin
          cap_low = 1'b1;
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (ext_ack) begin
          cap_high = 1'b1;
          state_d  = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state     = state_q;
  assign err_pulse = err_q;
endmodule

// File: rtl/xfp_assembler.sv
module xfp_assembler #(
  parameter int DATA_W = 32,
  parameter int LOW_W  = 16,
  parameter int WORD_W = DATA_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_low,
  input  logic              cap_high,
  input  logic [DATA_W-1:0] rdata,
  output logic [WORD_W-1:0] word
);
  logic [LOW_W-1:0]  low_q, low_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              unused_upper;

  assign unused_upper = ^rdata[DATA_W-1:LOW_W];

  always_comb begin
    low_d  = low_q;
    word_d = word_q;
    if (cap_low)  low_d  = rdata[LOW_W-1:0];
    if (cap_high) word_d = {rdata, low_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      word_q <= '0;
    end else begin
      if (cap_low)  low_q  <= low_d;
      if (cap_high) word_q <= word_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/xfetch_packer.sv
module xfetch_packer
  import xfp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int LOW_W    = 16,
  parameter int BANK_LSB = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic [ADDR_W-1:0]        ext_addr,
  output logic                     ext_cs,
  output logic                     ext_rd,
  input  logic                     ext_ack,
  input  logic [DATA_W-1:0]        ext_rdata,
  output logic                     rsp_valid,
  output logic                     rsp_kind,
  output logic [DATA_W+LOW_W-1:0]  rsp_data,
  output logic                     rsp_err
);
  localparam int WORD_W    = DATA_W + LOW_W;
  localparam int SYNC_DEPTH = 2;

  // reset asserts at once, releases after SYNC_DEPTH clock edges
  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_DEPTH-1];

  xfp_state_e        state;
  logic              load_req, cap_low, cap_high, err_pulse;
  logic              in_bank;
  logic [ADDR_W-1:0] addr_q, addr_d;
  xfp_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] mapped;
  logic              busy_rd;

  xfp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_in_bank(in_bank),
    .ext_ack    (ext_ack),
    .state      (state),
    .load_req   (load_req),
    .cap_low    (cap_low),
    .cap_high   (cap_high),
    .err_pulse  (err_pulse)
  );

  xfp_addr_map #(
    .ADDR_W  (ADDR_W),
    .BANK_LSB(BANK_LSB)
  ) u_map (
    .held_addr    (addr_q),
    .phase_odd    (state == ST_HIGH),
    .probe_addr   (req_addr),
    .mapped_addr  (mapped),
    .probe_in_bank(in_bank)
  );

  xfp_assembler #(
    .DATA_W(DATA_W),
    .LOW_W (LOW_W),
    .WORD_W(WORD_W)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cap_low (cap_low),
    .cap_high(cap_high),
    .rdata   (ext_rdata),
    .word    (rsp_data)
  );

  // request holding registers
  always_comb begin
    addr_d = addr_q;
    kind_d = kind_q;
    if (load_req) begin
      addr_d = req_addr;
      kind_d = xfp_kind_e'(req_kind);
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      addr_q <= '0;
      kind_q <= KIND_FETCH;
    end else if (load_req) begin
      addr_q <= addr_d;
      kind_q <= kind_d;
    end
  end

  assign busy_rd   = (state == ST_LOW) || (state == ST_HIGH);
  assign ext_addr  = busy_rd ? mapped : '0;
  assign ext_cs    = busy_rd && (|mapped[ADDR_W-1:BANK_LSB]);
  assign ext_rd    = busy_rd;
  assign rsp_valid = (state == ST_DONE);
  assign rsp_kind  = rsp_valid && (kind_q == KIND_XREG);
  assign rsp_err   = err_pulse;
endmodule

// File: rtl/xfp_chk.sv
module xfp_chk #(
  parameter int ADDR_W   = 24,
  parameter int BANK_LSB = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ext_cs,
  input logic              ext_rd,
  input logic              ext_ack,
  input logic              rsp_valid,
  input logic              rsp_err
);
  // R1
  even_then_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd && ext_ack && !ext_addr[0]) |=> (ext_rd && ext_addr[0]));

  // R3
  strobe_select_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rd == ext_cs);

  // R3
  select_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs |-> (|ext_addr[ADDR_W-1:BANK_LSB]));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd && !ext_ack) |=> (ext_rd && $stable(ext_addr)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  done_after_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(ext_rd && ext_ack && ext_addr[0]));

  // R6
  refuse_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_rd && !rsp_valid && !(|req_addr[ADDR_W-1:BANK_LSB]))
      |=> (rsp_err && !ext_rd));
endmodule

bind xfetch_packer xfp_chk #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)) i_chk (.*);

// File: tb/test_xfetch_packer.sv
module test_xfetch_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {kind, address[23:0], waits on first read, waits on second read}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 24'h020008, 4'd0, 4'd0},
    {1'b0, 24'h02FFFF, 4'd1, 4'd0},
    {1'b1, 24'h7A5A5A, 4'd0, 4'd3},
    {1'b0, 24'hFFFFFF, 4'd2, 4'd2},
    {1'b1, 24'h030000, 4'd4, 4'd1},
    {1'b0, 24'h021234, 4'd0, 4'd1},
    {1'b1, 24'h13ABCD, 4'd3, 4'd0},
    {1'b0, 24'h800000, 4'd0, 4'd0}
  };

  logic        clk, rst_n;
  logic        req_valid, req_kind;
  logic [23:0] req_addr;
  logic [23:0] ext_addr;
  logic        ext_cs, ext_rd, ext_ack;
  logic [31:0] ext_rdata;
  logic        rsp_valid, rsp_kind, rsp_err;
  logic [47:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  xfetch_packer i_xfetch_packer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .ext_addr(ext_addr), .ext_cs(ext_cs), .ext_rd(ext_rd),
    .ext_ack(ext_ack), .ext_rdata(ext_rdata), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [23:0] a);
    return {~a[15:0], a[23:8] ^ 16'hC3A5};
  endfunction

  function automatic logic [23:0] ext_of(input logic [23:0] a, input logic odd);
    return {a[23:17], a[15:0], odd};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle_chk(input string tag);
    chk({tag, " R3 select idle"}, 64'(ext_cs), 64'd0);
    chk({tag, " R3 strobe idle"}, 64'(ext_rd), 64'd0);
    chk({tag, " R3 addr idle"}, 64'(ext_addr), 64'd0);
    chk({tag, " R5 done idle"}, 64'(rsp_valid), 64'd0);
    chk({tag, " R8 kind idle"}, 64'(rsp_kind), 64'd0);
  endtask

  // drives one request and follows it to completion; poke drives stray requests while busy
  task automatic run_req(input logic kind, input logic [23:0] a, input int w1,
                         input int w2, input bit poke);
    logic [23:0] ev, od;
    logic [47:0] expw;
    ev = ext_of(a, 1'b0);
    od = ext_of(a, 1'b1);
    expw = {mem_word(od), mem_word(ev)[15:0]};
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= w1; k++) begin
      chk("R1 even address", 64'(ext_addr), 64'(ev));
      chk("R3 select during read", 64'(ext_cs), 64'd1);
      chk("R3 strobe during read", 64'(ext_rd), 64'd1);
      ext_ack = (k == w1);
      ext_rdata = (k == w1) ? mem_word(ev) : 32'h5555_AAAA ^ 32'(k);
      if (poke && k == 0) begin
        req_valid = 1'b1; req_kind = ~kind; req_addr = 24'h0A0000;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int k = 0; k <= w2; k++) begin
      chk(poke ? "R7 odd address after stray request" : "R1 odd address",
          64'(ext_addr), 64'(od));
      chk("R4 strobe held", 64'(ext_rd), 64'd1);
      chk("R5 no early done", 64'(rsp_valid), 64'd0);
      ext_ack = (k == w2);
      ext_rdata = (k == w2) ? mem_word(od) : 32'hA5A5_0F0F ^ 32'(k);
      @(negedge clk);
    end
    ext_ack = 1'b0;
    ext_rdata = 32'hDEAD_BEEF;
    chk("R5 done pulse", 64'(rsp_valid), 64'd1);
    chk("R2 assembled word", 64'(rsp_data), 64'(expw));
    chk("R8 kind echo", 64'(rsp_kind), 64'(kind));
    chk("R3 strobe low in done", 64'(ext_rd), 64'd0);
    if (poke) begin
      req_valid = 1'b1; req_kind = kind; req_addr = 24'h050000;
    end
    @(negedge clk);
    req_valid = 1'b0;
    idle_chk(poke ? "R7 done-cycle request ignored" : "after done");
    chk("R5 word holds", 64'(rsp_data), 64'(expw));
  endtask

  task automatic refuse(input logic kind, input logic [23:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 error pulse", 64'(rsp_err), 64'd1);
    chk("R6 no read", 64'(ext_rd), 64'd0);
    chk("R6 no select", 64'(ext_cs), 64'd0);
    @(negedge clk);
    chk("R6 error one cycle", 64'(rsp_err), 64'd0);
    idle_chk("R6 still idle");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 1'b0; req_addr = '0;
    ext_ack = 1'b0; ext_rdata = '0;
    #(CLK_PERIOD * 3 + 2);
    idle_chk("R9 reset state");
    chk("R9 error low in reset", 64'(rsp_err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 worked example
    run_req(1'b0, 24'h020008, 0, 0, 1'b0);

    for (int i = 0; i < NVEC; i++)
      run_req(VEC[i][32], VEC[i][31:8], int'(VEC[i][7:4]), int'(VEC[i][3:0]), 1'b0);

    // R7 stray requests during a read and during done
    run_req(1'b1, 24'h040010, 2, 1, 1'b1);

    // R6 both types refused below the bank
    refuse(1'b0, 24'h010008);
    refuse(1'b1, 24'h000100);
    run_req(1'b0, 24'h020000, 1, 1, 1'b0);

    // R9 reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_kind = 1'b1; req_addr = 24'h060004;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 read started", 64'(ext_rd), 64'd1);
    rst_n = 1'b0;
    #1;
    idle_chk("R9 async reset mid read");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_chk("R9 after release");
    run_req(1'b1, 24'h060004, 1, 0, 1'b0);

    finish_run();
  end
endmodule